// File: doc/BRIEF.md
# Tagged Translation Buffer with Hardware Page-Table Fetch

This block translates a logical address into a physical address. The logical address is cut in two. The upper bits form a virtual page number. The lower `OFF_W` bits are the byte offset, and they pass through unchanged. A small fully associative store of recent translations is searched in parallel. Each stored translation is tagged with an address-space identifier, so a change of running process needs no flush. A stored entry can also be pinned, and a pinned entry is never replaced or flushed.

On a miss the block itself issues one read to a single-level page table in memory, at `ptbr + vpn`. It first checks the page number against a table length. It then checks the returned entry for validity and write permission, installs it, and answers. A fault is reported with a cause code on the response instead of an address.

Requests, responses and page-table traffic all use valid/ready handshakes. A request is taken only while `req_ready` is high, and `req_ready` is high only when nothing is in flight. A response stays on the port, unchanged, until `rsp_ready` is seen high at a clock edge. A page-table read request stays asserted with a stable address until `pt_req_ready` is seen. The returned entry is taken on the edge where both `pt_rsp_valid` and `pt_rsp_ready` are high. Only one miss is ever outstanding.

Top module: `asid_tlb`

## Requirements
- R1: The physical address is `{frame number, offset}`, where the offset is the low `OFF_W` bits of the request address, unchanged. On any fault `rsp_paddr` is zero.
- R2: A hit gives `rsp_valid` in the cycle right after the accepting edge and issues no page-table read. A hit needs an entry whose page number and identifier both equal the request page number and `cur_asid`.
- R3: On a miss the block issues exactly one page-table read, at address `ptbr + vpn`. The entry is decoded as bit 0 = valid, bit 1 = writable, bit 2 = pinned, and bits `[PFN_W+2:3]` = frame number. A valid entry is installed under the identifier the request carried.
- R4: A page number at or above `ptlr` answers with cause 2 (length), with no page-table read.
- R5: A fetched entry whose valid bit is 0 answers with cause 1 (invalid), and it is not installed.
- R6: A write to a page whose writable bit is 0 answers with cause 3 (write-protect), on both hit and miss. Reads of such a page succeed with cause 0.
- R7: A valid fetched entry goes into the lowest-numbered empty slot. When no slot is empty it replaces the first unpinned slot at or after a round-robin pointer, and the pointer then moves to the slot after the one replaced. When every slot is pinned, nothing is installed.
- R8: A pinned entry is never replaced and never cleared by a flush.
- R9: A one-cycle `flush` pulse clears every unpinned entry. With `flush_by_asid` high, it clears only the unpinned entries whose identifier equals `flush_asid`. The flush takes effect from the next cycle.
- R10: `req_ready` is low while a request is in flight. `rsp_valid`, `rsp_paddr` and `rsp_cause` hold until they are accepted. `pt_req_valid` and `pt_req_addr` hold until they are accepted.
- R11: An entry installed under one identifier misses under another. The entry is still present when the first identifier returns, with no flush in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | ASID_W | Identifier of the running process |
| ptbr | input | ADDR_W | Page-table base address |
| ptlr | input | VA_W-OFF_W+1 | Number of page-table entries |
| flush | input | 1 | One-cycle flush pulse |
| flush_by_asid | input | 1 | Restrict flush to `flush_asid` |
| flush_asid | input | ASID_W | Identifier to flush |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high |
| req_addr | input | VA_W | Logical address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted when high |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, zero on fault |
| rsp_cause | output | 2 | 0 none, 1 invalid, 2 length, 3 write-protect |
| pt_req_valid | output | 1 | Page-table read request |
| pt_req_ready | input | 1 | Page-table read accepted |
| pt_req_addr | output | ADDR_W | Page-table entry address |
| pt_rsp_valid | input | 1 | Page-table data valid |
| pt_rsp_ready | output | 1 | Block can take page-table data |
| pt_rsp_data | input | PFN_W+3 | Page-table entry |

## Verification
The bench builds the block with 4 entries, an 8-bit page number and a 4-bit offset. With only 4 slots and a few hot pages, the random traffic often fills every slot. That brings round-robin eviction into reach, along with pinned entries that block a slot and, at the end, the case where every slot is pinned. A 3-bit identifier with two active values exercises the tag match. A table length inside the page-number range puts the length fault and its exact boundary within reach of the random traffic.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_INVALID = 2'd1,
    CAUSE_LENGTH  = 2'd2,
    CAUSE_WPROT   = 2'd3
  } trap_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PTREQ  = 2'd1,
    ST_PTWAIT = 2'd2,
    ST_RESP   = 2'd3
  } walk_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 8,
  parameter int PFN_W   = 10,
  parameter int ASID_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_writable,
  output logic [ENTRIES-1:0] ent_valid,
  output logic [ENTRIES-1:0] ent_wired,
  input  logic              install_en,
  input  logic [IDX_W-1:0]  install_idx,
  input  logic [VPN_W-1:0]  install_vpn,
  input  logic [ASID_W-1:0] install_asid,
  input  logic [PFN_W-1:0]  install_pfn,
  input  logic              install_w,
  input  logic              install_wired,
  input  logic              flush_en,
  input  logic              flush_by_asid,
  input  logic [ASID_W-1:0] flush_asid
);
  logic [VPN_W-1:0]  e_vpn  [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic [PFN_W-1:0]  e_pfn  [ENTRIES];
  logic [ENTRIES-1:0] e_w;
  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_wired[i] <= 1'b0;
        e_w[i]       <= 1'b0;
        e_vpn[i]     <= '0;
        e_asid[i]    <= '0;
        e_pfn[i]     <= '0;
      end else if (install_en && install_idx == IDX_W'(i)) begin
        ent_valid[i] <= 1'b1;
        ent_wired[i] <= install_wired;
        e_w[i]       <= install_w;
        e_vpn[i]     <= install_vpn;
        e_asid[i]    <= install_asid;
        e_pfn[i]     <= install_pfn;
      end else if (flush_en && !ent_wired[i] &&
                   (!flush_by_asid || e_asid[i] == flush_asid)) begin
        ent_valid[i] <= 1'b0;
      end
    end

    assign hit_vec[i] = ent_valid[i] && e_vpn[i] == lk_vpn && e_asid[i] == lk_asid;

    AST_WIRED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid[i] && ent_wired[i]) |=> ent_valid[i]); // R8
  end

  always_comb begin
    lk_hit      = 1'b0;
    lk_pfn      = '0;
    lk_writable = 1'b0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (hit_vec[k]) begin
        lk_hit      = 1'b1;
        lk_pfn      = e_pfn[k];
        lk_writable = e_w[k];
      end
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_NO_WIRED_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    install_en |-> !(ent_valid[install_idx] && ent_wired[install_idx])); // R8
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ENTRIES-1:0] ent_wired,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               victim_ok
);
  logic [IDX_W-1:0] rr_ptr;
  logic             free_found;
  int               j;

  always_comb begin
    free_found = 1'b0;
    victim_ok  = 1'b0;
    victim_idx = '0;
    j          = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && !ent_valid[i]) begin
        free_found = 1'b1;
        victim_idx = IDX_W'(i);
      end
    end
    if (free_found) begin
      victim_ok = 1'b1;
    end else begin
      for (int k = 0; k < ENTRIES; k++) begin
        j = int'(rr_ptr) + k;
        if (j >= ENTRIES) j = j - ENTRIES;
        if (!victim_ok && !ent_wired[j]) begin
          victim_ok  = 1'b1;
          victim_idx = IDX_W'(j);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (advance && !free_found) begin
      rr_ptr <= (int'(victim_idx) == ENTRIES - 1) ? '0 : victim_idx + 1'b1;
    end
  end

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !(&ent_valid)) |-> !ent_valid[victim_idx]); // R7
  AST_NOT_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !(ent_valid[victim_idx] && ent_wired[victim_idx])); // R7
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int VA_W    = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 10,
  parameter int ASID_W  = 4,
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PTE_W  = PFN_W + 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ASID_W-1:0]      cur_asid,
  input  logic [ADDR_W-1:0]      ptbr,
  input  logic [VPN_W:0]         ptlr,
  input  logic                   flush,
  input  logic                   flush_by_asid,
  input  logic [ASID_W-1:0]      flush_asid,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_addr,
  input  logic                   req_write,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]             rsp_cause,
  output logic                   pt_req_valid,
  input  logic                   pt_req_ready,
  output logic [ADDR_W-1:0]      pt_req_addr,
  input  logic                   pt_rsp_valid,
  output logic                   pt_rsp_ready,
  input  logic [PTE_W-1:0]       pt_rsp_data
);
  import tlb_pkg::*;

  walk_state_e state;
  logic [VPN_W-1:0]  q_vpn;
  logic [OFF_W-1:0]  q_off;
  logic              q_write;
  logic [ASID_W-1:0] q_asid;

  logic [VPN_W-1:0]  req_vpn;
  logic              len_bad, accept;
  logic              lk_hit, lk_writable;
  logic [PFN_W-1:0]  lk_pfn;
  logic [ENTRIES-1:0] ent_valid, ent_wired;
  logic [IDX_W-1:0]  victim_idx;
  logic              victim_ok, install_en, pte_take;
  logic              pte_valid, pte_w, pte_wired;
  logic [PFN_W-1:0]  pte_pfn;

  assign req_vpn  = req_addr[VA_W-1:OFF_W];
  assign len_bad  = {1'b0, req_vpn} >= ptlr;
  assign req_ready = (state == ST_IDLE);
  assign accept   = req_valid && req_ready;

  assign pte_valid = pt_rsp_data[0];
  assign pte_w     = pt_rsp_data[1];
  assign pte_wired = pt_rsp_data[2];
  assign pte_pfn   = pt_rsp_data[PTE_W-1:3];

  assign pt_req_valid = (state == ST_PTREQ);
  assign pt_req_addr  = ptbr + ADDR_W'(q_vpn);
  assign pt_rsp_ready = (state == ST_PTWAIT);
  assign pte_take     = pt_rsp_valid && pt_rsp_ready;
  assign install_en   = pte_take && pte_valid && victim_ok;
  assign rsp_valid    = (state == ST_RESP);

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) i_cam (
    .clk, .rst_n,
    .lk_vpn(req_vpn), .lk_asid(cur_asid),
    .lk_hit, .lk_pfn, .lk_writable,
    .ent_valid, .ent_wired,
    .install_en, .install_idx(victim_idx), .install_vpn(q_vpn),
    .install_asid(q_asid), .install_pfn(pte_pfn), .install_w(pte_w),
    .install_wired(pte_wired),
    .flush_en(flush), .flush_by_asid, .flush_asid
  );

  tlb_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk, .rst_n, .ent_valid, .ent_wired,
    .advance(install_en), .victim_idx, .victim_ok
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      q_vpn     <= '0;
      q_off     <= '0;
      q_write   <= 1'b0;
      q_asid    <= '0;
      rsp_paddr <= '0;
      rsp_cause <= CAUSE_NONE;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          q_vpn   <= req_vpn;
          q_off   <= req_addr[OFF_W-1:0];
          q_write <= req_write;
          q_asid  <= cur_asid;
          if (len_bad) begin
            rsp_paddr <= '0;
            rsp_cause <= CAUSE_LENGTH;
            state     <= ST_RESP;
          end else if (lk_hit) begin
            if (req_write && !lk_writable) begin
              rsp_paddr <= '0;
              rsp_cause <= CAUSE_WPROT;
            end else begin
              rsp_paddr <= {lk_pfn, req_addr[OFF_W-1:0]};
              rsp_cause <= CAUSE_NONE;
            end
            state <= ST_RESP;
          end else begin
            state <= ST_PTREQ;
          end
        end
        ST_PTREQ: if (pt_req_ready) state <= ST_PTWAIT;
        ST_PTWAIT: if (pte_take) begin
          if (!pte_valid) begin
            rsp_paddr <= '0;
            rsp_cause <= CAUSE_INVALID;
          end else if (q_write && !pte_w) begin
            rsp_paddr <= '0;
            rsp_cause <= CAUSE_WPROT;
          end else begin
            rsp_paddr <= {pte_pfn, q_off};
            rsp_cause <= CAUSE_NONE;
          end
          state <= ST_RESP;
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause))); // R10
  AST_PTREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid && !pt_req_ready) |=> (pt_req_valid && $stable(pt_req_addr))); // R10
  AST_LEN_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && len_bad) |=> (rsp_valid && rsp_cause == 2'd2)); // R4
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !len_bad && lk_hit) |=> rsp_valid); // R2
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != 2'd0) |-> rsp_paddr == '0); // R1
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid || pt_rsp_ready || rsp_valid) |-> !req_ready); // R10
endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 12, OFF_W = 4, PFN_W = 8, ASID_W = 3, ENTRIES = 4, ADDR_W = 16;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PTE_W = PFN_W + 3;
  localparam int PTLR_V = 'h30;

  logic clk = 0, rst_n = 0;
  logic [ASID_W-1:0] cur_asid = 1;
  logic [ADDR_W-1:0] ptbr = 16'h0300;
  logic [VPN_W:0] ptlr = PTLR_V;
  logic flush = 0, flush_by_asid = 0;
  logic [ASID_W-1:0] flush_asid = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 0;
  logic [VA_W-1:0] req_addr = 0;
  logic req_ready, rsp_valid, pt_req_valid, pt_rsp_ready;
  logic [PFN_W+OFF_W-1:0] rsp_paddr;
  logic [1:0] rsp_cause;
  logic pt_req_ready = 0, pt_rsp_valid = 0;
  logic [ADDR_W-1:0] pt_req_addr;
  logic [PTE_W-1:0] pt_rsp_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .ASID_W(ASID_W),
             .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_asid_tlb (.*);

  int checks = 0, fails = 0, walks = 0;
  bit done = 0;
  logic [PTE_W-1:0] pt_mem [256];

  // model of translation store
  bit m_v [ENTRIES]; bit m_w [ENTRIES]; bit m_wired [ENTRIES];
  int m_vpn [ENTRIES]; int m_asid [ENTRIES]; int m_pfn [ENTRIES];
  int m_rr = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_find(int vpn, int asid);
    for (int i = 0; i < ENTRIES; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  task automatic m_install(int vpn, int asid, logic [PTE_W-1:0] pte);
    int slot = -1;
    for (int i = 0; i < ENTRIES; i++) if (slot < 0 && !m_v[i]) slot = i;
    if (slot < 0) begin
      for (int k = 0; k < ENTRIES; k++) begin
        int j = (m_rr + k) % ENTRIES;
        if (slot < 0 && !m_wired[j]) slot = j;
      end
      if (slot >= 0) m_rr = (slot + 1) % ENTRIES;
    end
    if (slot >= 0) begin
      m_v[slot] = 1; m_vpn[slot] = vpn; m_asid[slot] = asid;
      m_pfn[slot] = int'(pte[PTE_W-1:3]); m_w[slot] = pte[1]; m_wired[slot] = pte[2];
    end
  endtask

  // page-table memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (pt_req_valid) begin
        logic [ADDR_W-1:0] a;
        repeat ($urandom % 3) @(negedge clk);
        pt_req_ready = 1; a = pt_req_addr;
        @(negedge clk);
        pt_req_ready = 0; walks++;
        repeat ($urandom % 3) @(negedge clk);
        pt_rsp_data = pt_mem[8'(a - ptbr)];
        pt_rsp_valid = 1;
        while (!pt_rsp_ready) @(negedge clk);
        @(negedge clk);
        pt_rsp_valid = 0;
      end
    end
  end

  // R2 R3 R4 R5 R6 R7 R11: one access checked against the model
  task automatic access(int vpn, int off, bit wr);
    int cyc, w0, hit_i, exp_walks, exp_cause, exp_pa;
    logic [PTE_W-1:0] pte;
    hit_i = m_find(vpn, cur_asid);
    exp_walks = 0; exp_cause = 0; exp_pa = 0;
    if (vpn >= int'(ptlr)) exp_cause = 2;
    else if (hit_i >= 0) begin
      if (wr && !m_w[hit_i]) exp_cause = 3; else exp_pa = (m_pfn[hit_i] << OFF_W) | off;
    end else begin
      exp_walks = 1; pte = pt_mem[vpn];
      if (!pte[0]) exp_cause = 1;
      else begin
        m_install(vpn, cur_asid, pte);
        if (wr && !pte[1]) exp_cause = 3; else exp_pa = (int'(pte[PTE_W-1:3]) << OFF_W) | off;
      end
    end
    w0 = walks;
    @(negedge clk);
    req_valid = 1; req_addr = VA_W'((vpn << OFF_W) | off); req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; cyc = 1;
    while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
    if (exp_walks == 0 && exp_cause != 2) check(cyc == 1, "R2 hit latency", cyc, 1);
    check(int'(rsp_cause) == exp_cause, (exp_cause == 2) ? "R4 cause" :
          (exp_cause == 1) ? "R5 cause" : (exp_cause == 3) ? "R6 cause" : "R3 cause",
          rsp_cause, exp_cause);
    check(int'(rsp_paddr) == exp_pa, "R1 paddr", rsp_paddr, exp_pa);
    repeat ($urandom % 3) begin
      @(negedge clk);
      check(rsp_valid && int'(rsp_paddr) == exp_pa, "R10 response hold", rsp_paddr, exp_pa);
    end
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    check(walks - w0 == exp_walks, "R7 R11 walk count", walks - w0, exp_walks);
  endtask

  task automatic do_flush(bit by_asid, int asid);
    @(negedge clk);
    flush = 1; flush_by_asid = by_asid; flush_asid = ASID_W'(asid);
    @(negedge clk);
    flush = 0;
    for (int i = 0; i < ENTRIES; i++)
      if (!m_wired[i] && (!by_asid || m_asid[i] == asid)) m_v[i] = 0;
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) begin
      logic [PTE_W-1:0] p;
      p[PTE_W-1:3] = PFN_W'($urandom);
      p[2] = 0; p[1] = ($urandom % 2) != 0; p[0] = ($urandom % 5) != 0;
      pt_mem[i] = p;
    end
    for (int i = 'h10; i < 'h14; i++) pt_mem[i] = {PFN_W'(8'hA0 + i), 3'b111};
    pt_mem['h20] = {8'h5C, 3'b011};
    pt_mem['h21] = {8'h33, 3'b001};
    pt_mem['h22] = {8'h44, 3'b000};
    for (int i = 0; i < ENTRIES; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R10 reset req_ready", req_ready, 1);
    check(rsp_valid == 0, "R10 reset rsp_valid", rsp_valid, 0);
    check(pt_req_valid == 0, "R3 reset pt_req_valid", pt_req_valid, 0);

    // directed
    access('h10, 3, 0);           // pinned install (R8)
    access('h11, 4, 1);
    access('h20, 5, 1);           // miss, writable
    access('h20, 6, 1);           // hit (R2)
    access('h21, 7, 1);           // write protect on miss (R6)
    access('h21, 8, 0);           // read ok on hit
    access('h21, 9, 1);           // write protect on hit (R6)
    access('h22, 1, 0);           // invalid (R5)
    access('h22, 1, 0);           // still walks: not installed
    access(PTLR_V - 1, 2, 0);     // boundary below length
    access(PTLR_V, 2, 0);         // length fault (R4)
    access('h10, 1, 0);           // pinned still there (R8)
    cur_asid = 2;
    access('h20, 5, 0);           // other identifier misses (R11)
    cur_asid = 1;
    access('h20, 5, 0);           // back again
    do_flush(1, 2);               // R9 by identifier
    access('h20, 5, 0);
    cur_asid = 2;
    access('h20, 5, 0);
    cur_asid = 1;
    do_flush(0, 0);               // R9 all unpinned
    access('h20, 5, 0);
    access('h10, 5, 0);           // R8 survives flush

    // random
    for (int n = 0; n < 400; n++) begin
      int vpn;
      vpn = (($urandom % 8) == 0) ? PTLR_V - 1 + int'($urandom % 3) : 'h20 + int'($urandom % 6);
      cur_asid = ASID_W'(1 + $urandom % 2);
      if (($urandom % 40) == 0) do_flush(($urandom % 2) != 0, 1 + int'($urandom % 2));
      access(vpn, int'($urandom % 16), ($urandom % 2) != 0);
    end

    // every slot pinned: nothing installs (R7)
    cur_asid = 1;
    access('h10, 0, 0);
    access('h11, 0, 0);
    access('h12, 0, 0);
    access('h13, 0, 0);
    access('h23, 0, 0);
    access('h23, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule